// File: doc/BRIEF.md
# Parity-Configurable Serial Transmitter

This block sends parallel characters as asynchronous serial frames. A character written into a one-entry holding register moves into a shift stage when the line is free. It then leaves the block as one low start bit, 5 to 8 data bits with the least significant bit first, an optional extra bit, and one high stop bit. Each bit lasts sixteen pulses of a 16x bit-clock enable that a separate baud generator supplies.

The extra bit has four uses, chosen by a 2-bit mode input:
- computed parity (odd or even) over the data bits that are sent;
- a forced constant;
- no extra bit;
- a multidrop address/data marker whose value comes from the parity-type input.

Software watches two status outputs. `tx_ready` means the holding register can take a character. `tx_empty` means nothing is waiting and nothing is on the wire.

The core is a five-state machine:
- `ST_IDLE`: the line is high and no character is in progress.
- `ST_START`: the start bit is being sent.
- `ST_DATA`: data bits are being sent.
- `ST_EXTRA`: the parity or address/data bit is being sent.
- `ST_STOP`: the stop bit is being sent.

The transitions are:
- IDLE to START on a bit-clock pulse while enabled with a character waiting (a load).
- START to DATA at the end of the start bit.
- DATA to DATA at the end of each data bit except the last.
- DATA to EXTRA or to STOP after the last data bit, depending on whether an extra bit is framed.
- EXTRA to STOP at the end of the extra bit.
- STOP to START (a back-to-back load) or to IDLE at the end of the stop bit.

Top module: `frame_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame is one 0 start bit, then the data bits LSB first, then one 1 stop bit. Each bit lasts 16 `tick_16x` pulses, and `txd` changes only on a clock edge where `tick_16x` is 1.
- R3: `len_sel` values 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Only the low bits of `wr_data` are sent, and start, extra and stop bits are not counted in this length.
- R4: With `par_mode` 00 an extra bit is sent after the data. It makes the count of ones in the sent data bits plus the extra bit even when `par_type` is 0, and odd when `par_type` is 1. Data bits above the selected length do not affect it.
- R5: With `par_mode` 01 an extra bit is sent whose value is `par_type`, whatever the data.
- R6: With `par_mode` 10 no extra bit is sent, and `par_type` has no effect on the frame.
- R7: With `par_mode` 11 (multidrop) an extra bit is sent whose value is `par_type`: 1 marks an address character and 0 a data character.
- R8: `len_sel`, `par_mode` and `par_type` are captured when a character starts. Changing them during a frame does not alter that frame.
- R9: `tx_ready` is 1 exactly when the holding register is empty. A `wr_valid` pulse while `tx_ready` is 0 is discarded.
- R10: `tx_empty` falls in the cycle after an accepted write. It stays 0 until the stop bit of the last character has ended and no further character is waiting.
- R11: While `en` is 0 no new frame starts, and `txd` stays 1 between frames. A frame already in progress when `en` falls is sent to the end.
- R12: If a character is waiting when a stop bit ends and `en` is 1, its start bit follows at once with no idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmitter enable |
| tick_16x | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length code (5 + value bits) |
| par_mode | input | 2 | Extra-bit mode: 00 parity, 01 forced, 10 none, 11 multidrop |
| par_type | input | 1 | Odd/even select, forced value, or address/data marker |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, high at rest |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The bench decodes frames at bit centres and compares every bit, including the extra bit. It uses data whose upper bits would change the parity if the length mask were wrong, so a design that computed parity over all eight bits would show a flipped extra bit at 5 and 7 data bits.

Forced and multidrop modes use data whose real parity differs from the requested value, so a mode decoder that fell back to computed parity is caught. No-parity mode is sent with both parity-type values; a leaked extra bit would show as a stretched stop position.

Other scenarios and the faults they expose:
- Configuration is changed and `en` is dropped mid-frame. A design that read its format live would corrupt the tail, and one that aborted would cut the frame short.
- A second write is issued while the holding register is full. A design that overwrote would send the wrong character.
- Two characters are queued back to back. A design that returned to idle before reloading would insert a gap the bench measures.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PM_PARITY = 2'b00,
        PM_FORCE  = 2'b01,
        PM_NONE   = 2'b10,
        PM_MULTI  = 2'b11
    } par_mode_e;

endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/frame_tx_fmt.sv
module frame_tx_fmt
    import frame_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = 2,
    parameter int CNT_W    = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [1:0]        par_mode,
    input  logic              par_type,
    output logic [CNT_W-1:0]  nbits,
    output logic              has_extra,
    output logic              extra_bit
);

    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    assign nbits = CNT_W'(MIN_BITS) + CNT_W'(len_sel);

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            assign masked[i] = data[i] && (CNT_W'(i) < nbits);
        end
    endgenerate

    assign ones_odd = ^masked;

    always_comb begin
        has_extra = 1'b1;
        extra_bit = 1'b1;
        unique case (par_mode_e'(par_mode))
            PM_PARITY: extra_bit = ones_odd ^ par_type;
            PM_FORCE:  extra_bit = par_type;
            PM_NONE:   has_extra = 1'b0;
            PM_MULTI:  extra_bit = par_type;
        endcase
    end

endmodule

// File: rtl/frame_tx_fsm.sv
module frame_tx_fsm
    import frame_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int CNT_W         = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [CNT_W-1:0]  cfg_nbits,
    input  logic              cfg_has_extra,
    input  logic              cfg_extra_bit,
    output logic              load,
    output logic              busy,
    output logic              txd
);

    localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

    tx_state_e         state, nxt;
    logic [SUB_W-1:0]  sub;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              x_en, x_bit;
    logic              bit_end, can_start;

    assign bit_end   = tick && (sub == SUB_LAST);
    assign can_start = en && hold_full;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && can_start) nxt = ST_START;
            ST_START: if (bit_end) nxt = ST_DATA;
            ST_DATA:  if (bit_end && left == CNT_W'(1)) nxt = x_en ? ST_EXTRA : ST_STOP;
            ST_EXTRA: if (bit_end) nxt = ST_STOP;
            ST_STOP:  if (bit_end) nxt = can_start ? ST_START : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign load = (state == ST_IDLE && tick && can_start) ||
                  (state == ST_STOP && bit_end && can_start);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit timer and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub   <= '0;
            shreg <= '0;
            left  <= '0;
            x_en  <= 1'b0;
            x_bit <= 1'b1;
        end else if (load) begin
            sub   <= '0;
            shreg <= hold_data;
            left  <= cfg_nbits;
            x_en  <= cfg_has_extra;
            x_bit <= cfg_extra_bit;
        end else if (tick && state != ST_IDLE) begin
            sub <= bit_end ? '0 : sub + SUB_W'(1);
            if (bit_end && state == ST_DATA) begin
                shreg <= shreg >> 1;
                left  <= left - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        txd  = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_START: txd  = 1'b0;
            ST_DATA:  txd  = shreg[0];
            ST_EXTRA: txd  = x_bit;
            ST_STOP:  txd  = 1'b1;
            default:  txd  = 1'b1;
        endcase
    end

endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int MIN_BITS      = 5,
    parameter int LEN_W         = 2,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick_16x,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [1:0]        par_mode,
    input  logic              par_type,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              hold_full, load, busy;
    logic [DATA_W-1:0] hold_data;
    logic [CNT_W-1:0]  nbits;
    logic              has_extra, extra_bit;

    frame_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (load),
        .full     (hold_full),
        .data     (hold_data)
    );

    frame_tx_fmt #(
        .DATA_W   (DATA_W),
        .MIN_BITS (MIN_BITS),
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W)
    ) u_fmt (
        .data      (hold_data),
        .len_sel   (len_sel),
        .par_mode  (par_mode),
        .par_type  (par_type),
        .nbits     (nbits),
        .has_extra (has_extra),
        .extra_bit (extra_bit)
    );

    frame_tx_fsm #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .tick          (tick_16x),
        .hold_full     (hold_full),
        .hold_data     (hold_data),
        .cfg_nbits     (nbits),
        .cfg_has_extra (has_extra),
        .cfg_extra_bit (extra_bit),
        .load          (load),
        .busy          (busy),
        .txd           (txd)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && !busy;

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic tick_16x,
    input logic wr_valid,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty
);

    // R2: the line moves only on bit-clock edges
    a_r2_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_16x |=> $stable(txd));

    // R9: an accepted write fills the holding register
    a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && wr_valid) |=> !tx_ready);

    // R10: empty implies holding register free
    a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

    // R10: a load leaves a character on the wire
    a_r10_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> !tx_empty);

    // R11: idle line is high
    a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R11: disabled and nothing written keeps the block empty
    a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && tx_empty && !wr_valid) |=> tx_empty);

endmodule

bind frame_tx frame_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick_16x (tick_16x),
    .wr_valid (wr_valid),
    .txd      (txd),
    .tx_ready (tx_ready),
    .tx_empty (tx_empty)
);

// File: tb/test_frame_tx.sv
`timescale 1ns/1ps
module test_frame_tx;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick_16x = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic [1:0] par_mode = 2'b00;
    logic       par_type = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, tx_ready, tx_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frame_tx i_frame_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick_16x(tick_16x),
        .len_sel(len_sel), .par_mode(par_mode), .par_type(par_type),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick_16x = (ph == 0);
            ph = (ph + 1) % TICK_DIV;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic calc_par(input logic [7:0] d, input int n, input logic odd);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p ^ odd;
    endfunction

    // decode one frame at bit centres; returns at mid stop bit
    task automatic expect_frame(input logic [7:0] d, input int n, input bit has_x,
                                input logic xb, input int maxwait, input string req);
        logic [11:0] exp_bits, got_bits;
        int nb, w;
        nb = 2 + n + (has_x ? 1 : 0);
        exp_bits = '1;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < n; i++) exp_bits[1+i] = d[i];
        if (has_x) exp_bits[1+n] = xb;
        got_bits = '1;
        w = 0;
        @(negedge clk);
        while (txd !== 1'b0 && w < maxwait) begin
            @(negedge clk);
            w++;
        end
        if (txd !== 1'b0) begin
            chk(1'b0, {req, " start bit not seen"}, w, maxwait);
            return;
        end
        repeat (BIT_CLKS / 2 - 1) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got_bits[i] = txd;
            if (i < nb - 1) repeat (BIT_CLKS) @(negedge clk);
        end
        chk(got_bits === exp_bits, {req, " frame bits"}, got_bits, exp_bits);
    endtask

    task automatic t_reset;
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
    endtask

    // R2 R3 R4: eight-bit computed parity, both senses
    task automatic t_parity8;
        len_sel = 2'b11; par_mode = 2'b00;
        par_type = 1'b0; send(8'hA5);
        expect_frame(8'hA5, 8, 1, calc_par(8'hA5, 8, 0), 2000, "R4 even A5");
        par_type = 1'b1; send(8'h3C);
        expect_frame(8'h3C, 8, 1, calc_par(8'h3C, 8, 1), 2000, "R4 odd 3C");
        par_type = 1'b0; send(8'h07);
        expect_frame(8'h07, 8, 1, 1'b1, 2000, "R2 R4 even 07");
    endtask

    // R3: shorter lengths, upper bits masked out of data and parity
    task automatic t_lengths;
        par_mode = 2'b00; par_type = 1'b0;
        len_sel = 2'b00; send(8'hE3);
        expect_frame(8'hE3, 5, 1, 1'b0, 2000, "R3 len5");
        len_sel = 2'b01; send(8'hC5);
        expect_frame(8'hC5, 6, 1, 1'b0, 2000, "R3 len6");
        len_sel = 2'b10; send(8'h81);
        expect_frame(8'h81, 7, 1, 1'b1, 2000, "R3 len7");
        len_sel = 2'b11;
    endtask

    task automatic t_force;
        par_mode = 2'b01;
        par_type = 1'b0; send(8'h01);
        expect_frame(8'h01, 8, 1, 1'b0, 2000, "R5 force0");
        par_type = 1'b1; send(8'h03);
        expect_frame(8'h03, 8, 1, 1'b1, 2000, "R5 force1");
    endtask

    task automatic t_none;
        par_mode = 2'b10;
        par_type = 1'b0; send(8'h96);
        expect_frame(8'h96, 8, 0, 1'b1, 2000, "R6 none type0");
        par_type = 1'b1; send(8'h96);
        expect_frame(8'h96, 8, 0, 1'b1, 2000, "R6 none type1");
    endtask

    task automatic t_multi;
        par_mode = 2'b11;
        par_type = 1'b1; send(8'h42);
        expect_frame(8'h42, 8, 1, 1'b1, 2000, "R7 address");
        par_type = 1'b0; send(8'h43);
        expect_frame(8'h43, 8, 1, 1'b0, 2000, "R7 data");
        par_mode = 2'b00;
    endtask

    task automatic t_latch;
        len_sel = 2'b11; par_mode = 2'b00; par_type = 1'b0;
        send(8'hC3);
        fork
            expect_frame(8'hC3, 8, 1, 1'b0, 2000, "R8 format held");
            begin
                repeat (150) @(negedge clk);
                len_sel = 2'b00; par_mode = 2'b10; par_type = 1'b1;
            end
        join
        len_sel = 2'b11; par_mode = 2'b00; par_type = 1'b0;
    endtask

    task automatic t_status;
        repeat (80) @(negedge clk);
        send(8'h5A);
        fork
            expect_frame(8'h5A, 8, 1, 1'b0, 2000, "R10 frame");
            begin
                chk(tx_ready === 1'b0, "R9 ready low after write", tx_ready, 0);
                chk(tx_empty === 1'b0, "R10 empty low after write", tx_empty, 0);
                repeat (TICK_DIV + 1) @(negedge clk);
                chk(tx_ready === 1'b1, "R9 ready after load", tx_ready, 1);
                chk(tx_empty === 1'b0, "R10 busy while sending", tx_empty, 0);
            end
        join
        chk(tx_empty === 1'b0, "R10 busy in stop bit", tx_empty, 0);
        repeat (BIT_CLKS) @(negedge clk);
        chk(tx_empty === 1'b1, "R10 empty after stop", tx_empty, 1);
    endtask

    task automatic t_drop_full;
        en = 1'b0;
        send(8'h11);
        send(8'h22);
        chk(tx_ready === 1'b0, "R9 full", tx_ready, 0);
        en = 1'b1;
        expect_frame(8'h11, 8, 1, 1'b0, 2000, "R9 first kept");
        repeat (BIT_CLKS * 4) @(negedge clk);
        chk(tx_empty === 1'b1 && txd === 1'b1, "R9 second discarded", {tx_empty, txd}, 3);
    endtask

    task automatic t_disable;
        bit low_seen = 0;
        en = 1'b0;
        send(8'h5A);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) low_seen = 1;
        end
        chk(!low_seen, "R11 no start while disabled", low_seen, 0);
        chk(tx_ready === 1'b0, "R11 char held", tx_ready, 0);
        en = 1'b1;
        fork
            expect_frame(8'h5A, 8, 1, 1'b0, 2000, "R11 finish after disable");
            begin
                repeat (100) @(negedge clk);
                en = 1'b0;
            end
        join
        send(8'h77);
        low_seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) low_seen = 1;
        end
        chk(!low_seen, "R11 idle high while disabled", low_seen, 0);
        en = 1'b1;
        expect_frame(8'h77, 8, 1, 1'b0, 2000, "R11 resume");
    endtask

    task automatic t_b2b;
        send(8'hF0);
        while (tx_ready !== 1'b1) @(negedge clk);
        fork
            expect_frame(8'hF0, 8, 1, 1'b0, 2000, "R12 first");
            send(8'h0F);
        join
        expect_frame(8'h0F, 8, 1, 1'b0, BIT_CLKS / 2 + 8, "R12 no gap");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        en = 1'b1;
        t_parity8();
        t_lengths();
        t_force();
        t_none();
        t_multi();
        t_latch();
        t_status();
        t_drop_full();
        t_disable();
        t_b2b();
        repeat (BIT_CLKS * 2) @(negedge clk);
        finish_run();
    end

endmodule